// File: doc/BRIEF.md
# Boundary-Scan Self-Test Pattern Engine

This block holds an 18-cell boundary-scan register and runs its built-in test algorithms. Sixteen data cells sit between the chip pins and the core logic. Eight cells observe the input pins and feed the core inputs. Eight cells observe the core outputs and drive the output pins. The two remaining cells are output-enable controls, and each one gates a group of four output pins.

Every cell has two parts. The shift element updates on the rising edge of the test clock. The shadow latch copies the shift element on the falling edge, and the shadow values are what reach the pins and the core.

While the run qualifier is high, a 2-bit opcode selects one of four algorithms:
- toggle the outputs while sampling the inputs;
- a 16-bit pseudo-random pattern generator;
- a 16-bit parallel signature compactor;
- a split mode, in which an 8-bit compactor on the input cells runs beside an 8-bit pattern generator on the output cells.

A serial scan path and an update strobe let the surrounding test controller load seeds and read results. The controller itself lies outside this block.

Top module: `bscan_selftest_engine`

## Requirements
- R1: A synchronous active-low reset clears every shift element and every shadow latch. After reset, pin_q, pin_oe, core_in and tdo all read 0.
- R2: While scan_shift is high, the register shifts one place toward cell 0 on each rising edge. scan_tdi enters cell 17 and tdo always shows cell 0. scan_shift takes priority over run_en.
- R3: With run_en and scan_shift both low, the shift elements hold. The shadow latches copy the shift elements on a falling edge only when run_en or upd_en is high, and otherwise hold.
- R4: Opcode 2'b00: the input cells (bits 15..8) load pin_in, and the output cells (bits 7..0) invert on each rising edge.
- R5: Opcode 2'b01: bits 15..0 shift up by one place. The new bit 0 is b15^b13^b12^b10. From a nonzero seed the sequence first returns to the seed after 65535 steps.
- R6: Opcode 2'b01 with bits 15..0 all zero leaves them at zero.
- R7: Opcode 2'b10: bits 15..0 take the R5 next state, XORed with {pin_in, core_out}.
- R8: Opcode 2'b11: the input cells take their 8-bit shifted state, with new bit 8 = b15^b13^b12^b11, XORed with pin_in. The output cells independently take their 8-bit shifted state, with new bit 0 = b7^b5^b4^b3.
- R9: No run operation changes control cells 17..16.
- R10: pin_q equals shadow bits 7..0 and core_in equals shadow bits 15..8. pin_oe[3:0] all equal shadow bit 16, and pin_oe[7:4] all equal shadow bit 17.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; shift on rise, shadow on fall |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Qualifier: test-idle instruction active |
| scan_shift | input | 1 | Serial shift of the whole register |
| scan_tdi | input | 1 | Serial data into cell 17 |
| upd_en | input | 1 | Copy shift elements into shadows on the falling edge |
| opcode | input | 2 | Algorithm select (R4, R5, R7, R8) |
| pin_in | input | 8 | Input pin values |
| core_out | input | 8 | Core output values |
| pin_q | output | 8 | Output pin drive data |
| pin_oe | output | 8 | Output pin drive enable (1 = driven, 0 = high impedance) |
| core_in | output | 8 | Values presented to the core inputs |
| tdo | output | 1 | Serial data from cell 0 |

## Verification
The assertions check every cycle that the scan path moves the register by one place and that the register holds while idle. They also check that the control cells never change during a run, that toggle mode inverts the output cells, that an all-zero pattern stays zero, and that the shadows hold on a falling edge without a strobe. The exact feedback polynomials, the signature compaction of pin and core data, the 65535-step period and the mapping of shadow bits onto pins and enables can only be shown by the bench, which compares its reference sequences with the pins.

// File: rtl/bscan_pkg.sv
// Package: shared opcode type and register geometry for the self-test engine.
// Assumes one input group and one output group of equal width.
package bscan_pkg;
    typedef enum logic [1:0] {
        OP_TOGGLE = 2'b00,
        OP_PRPG16 = 2'b01,
        OP_MISR16 = 2'b10,
        OP_SPLIT8 = 2'b11
    } bscan_op_e;
endpackage

// File: rtl/bscan_lfsr_step.sv
// Module: one combinational step of a Fibonacci LFSR, with optional parallel compaction.
// The state shifts toward the MSB and the feedback (XOR of the TAPS-selected bits) enters bit 0.
// With compress high, obs is XORed into the result.
// Assumes TAPS is a maximal-length tap mask for width W.
module bscan_lfsr_step #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] obs,
    input  logic         compress,
    output logic [W-1:0] nxt
);
    logic fb;

    // feedback bit and optional observation merge
    always_comb begin
        fb  = ^(cur & TAPS);
        nxt = {cur[W-2:0], fb} ^ (compress ? obs : '0);
    end
endmodule

// File: rtl/bscan_algo.sv
// Module: next-state selector for the data cells during a run.
// Picks the toggle/sample, 16-bit pattern, 16-bit signature or split 8/8 result by opcode.
// Assumes the data cells are laid out as {input group, output group}.
module bscan_algo
    import bscan_pkg::*;
#(
    parameter int             GW         = 8,
    parameter logic [2*GW-1:0] TAPS_WIDE = 16'hB400,
    parameter logic [GW-1:0]   TAPS_HALF = 8'hB8
) (
    input  logic [1:0]      opcode,
    input  logic [2*GW-1:0] data_cur,
    input  logic [GW-1:0]   pin_in,
    input  logic [GW-1:0]   core_out,
    output logic [2*GW-1:0] data_nxt
);
    localparam int DW = 2 * GW;

    logic [DW-1:0] wide_nxt;
    logic [GW-1:0] in_nxt;
    logic [GW-1:0] out_nxt;
    logic          wide_comp;
    bscan_op_e     op;

    // decode opcode into the typed view and the compaction select
    always_comb begin
        op        = bscan_op_e'(opcode);
        wide_comp = (op == OP_MISR16);
    end

    bscan_lfsr_step #(.W(DW), .TAPS(TAPS_WIDE)) u_wide (
        .cur(data_cur), .obs({pin_in, core_out}), .compress(wide_comp), .nxt(wide_nxt)
    );

    bscan_lfsr_step #(.W(GW), .TAPS(TAPS_HALF)) u_half_in (
        .cur(data_cur[DW-1:GW]), .obs(pin_in), .compress(1'b1), .nxt(in_nxt)
    );

    bscan_lfsr_step #(.W(GW), .TAPS(TAPS_HALF)) u_half_out (
        .cur(data_cur[GW-1:0]), .obs({GW{1'b0}}), .compress(1'b0), .nxt(out_nxt)
    );

    // choose the algorithm result
    always_comb begin
        unique case (op)
            OP_TOGGLE: data_nxt = {pin_in, ~data_cur[GW-1:0]};
            OP_PRPG16,
            OP_MISR16: data_nxt = wide_nxt;
            default:   data_nxt = {in_nxt, out_nxt};
        endcase
    end
endmodule

// File: rtl/bscan_shadow.sv
// Module: shadow latch bank, loaded from the shift elements on the falling test-clock edge.
// Loads only when the load strobe is high and otherwise holds.
// Assumes a synchronous active-low reset sampled on the same falling edge.
module bscan_shadow #(
    parameter int W = 18
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // falling-edge shadow update
    always_ff @(negedge tck) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    // shadows keep their value on a falling edge without a load strobe
    assert_shadow_hold_R3: assert property (@(negedge tck) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/bscan_selftest_engine.sv
// Module: boundary-scan register with run-time self-test algorithms.
// The shift elements update on rising tck (scan shift, or the opcode-selected algorithm).
// The shadows follow on falling tck and drive the pins, the enables and the core inputs.
// Assumes the test controller supplies run_en, scan_shift and upd_en.
module bscan_selftest_engine
    import bscan_pkg::*;
#(
    parameter int GW       = 8,
    parameter int OE_GROUP = 4
) (
    input  logic          tck,
    input  logic          rst_n,
    input  logic          run_en,
    input  logic          scan_shift,
    input  logic          scan_tdi,
    input  logic          upd_en,
    input  logic [1:0]    opcode,
    input  logic [GW-1:0] pin_in,
    input  logic [GW-1:0] core_out,
    output logic [GW-1:0] pin_q,
    output logic [GW-1:0] pin_oe,
    output logic [GW-1:0] core_in,
    output logic          tdo
);
    localparam int DW    = 2 * GW;
    localparam int CTL_W = GW / OE_GROUP;
    localparam int N     = DW + CTL_W;

    logic [N-1:0]  sr;
    logic [N-1:0]  shadow;
    logic [DW-1:0] data_nxt;

    bscan_algo #(.GW(GW)) u_algo (
        .opcode(opcode), .data_cur(sr[DW-1:0]), .pin_in(pin_in),
        .core_out(core_out), .data_nxt(data_nxt)
    );

    // rising-edge shift elements: scan path first, then the run algorithm
    always_ff @(posedge tck) begin
        if (!rst_n)          sr <= '0;
        else if (scan_shift) sr <= {scan_tdi, sr[N-1:1]};
        else if (run_en)     sr <= {sr[N-1:DW], data_nxt};
    end

    bscan_shadow #(.W(N)) u_shadow (
        .tck(tck), .rst_n(rst_n), .load(run_en | upd_en), .d(sr), .q(shadow)
    );

    // pin and core views of the shadow bank
    always_comb begin
        pin_q   = shadow[GW-1:0];
        core_in = shadow[DW-1:GW];
        tdo     = sr[0];
    end

    // one enable cell per group of OE_GROUP outputs
    for (genvar i = 0; i < GW; i++) begin : g_oe
        assign pin_oe[i] = shadow[DW + i / OE_GROUP];
    end

    // scan moves the register one place toward cell 0
    assert_scan_shift_R2: assert property (@(posedge tck) disable iff (!rst_n)
        scan_shift |=> (sr[N-2:0] == $past(sr[N-1:1])) && (sr[N-1] == $past(scan_tdi)));

    // idle register holds
    assert_idle_hold_R3: assert property (@(posedge tck) disable iff (!rst_n)
        (!scan_shift && !run_en) |=> $stable(sr));

    // toggle mode inverts the output cells
    assert_toggle_R4: assert property (@(posedge tck) disable iff (!rst_n)
        (run_en && !scan_shift && opcode == 2'b00) |=> (sr[GW-1:0] == ~$past(sr[GW-1:0])));

    // all-zero pattern seed stays zero
    assert_zero_seed_R6: assert property (@(posedge tck) disable iff (!rst_n)
        (run_en && !scan_shift && opcode == 2'b01 && sr[DW-1:0] == '0) |=> (sr[DW-1:0] == '0));

    // control cells untouched outside scan
    assert_ctl_hold_R9: assert property (@(posedge tck) disable iff (!rst_n)
        !scan_shift |=> $stable(sr[N-1:DW]));
endmodule

// File: tb/bscan_selftest_engine_tb.sv
module bscan_selftest_engine_tb;
    logic       tck = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       scan_shift = 1'b0;
    logic       scan_tdi = 1'b0;
    logic       upd_en = 1'b0;
    logic [1:0] opcode = 2'b00;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] core_out = 8'h00;
    logic [7:0] pin_q, pin_oe, core_in;
    logic       tdo;

    logic [17:0] m_sr = '0;
    logic [17:0] m_sh = '0;
    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    always #10 tck = ~tck;

    bscan_selftest_engine u_dut (
        .tck(tck), .rst_n(rst_n), .run_en(run_en), .scan_shift(scan_shift),
        .scan_tdi(scan_tdi), .upd_en(upd_en), .opcode(opcode), .pin_in(pin_in),
        .core_out(core_out), .pin_q(pin_q), .pin_oe(pin_oe), .core_in(core_in), .tdo(tdo)
    );

    function automatic logic [15:0] prpg16(logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [7:0] step8(logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic [17:0] m_run(logic [17:0] s, logic [1:0] op,
                                          logic [7:0] pi, logic [7:0] co);
        logic [15:0] d;
        case (op)
            2'b00:   d = {pi, ~s[7:0]};
            2'b01:   d = prpg16(s[15:0]);
            2'b10:   d = prpg16(s[15:0]) ^ {pi, co};
            default: d = {step8(s[15:8]) ^ pi, step8(s[7:0])};
        endcase
        return {s[17:16], d};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // drive one step (called at negedge+5), update the model, check after the next falling edge
    task automatic step(string req, logic r, logic run, logic sh, logic ti, logic up,
                        logic [1:0] op, logic [7:0] pi, logic [7:0] co);
        rst_n = r; run_en = run; scan_shift = sh; scan_tdi = ti; upd_en = up;
        opcode = op; pin_in = pi; core_out = co;
        if (!r)        m_sr = '0;
        else if (sh)   m_sr = {ti, m_sr[17:1]};
        else if (run)  m_sr = m_run(m_sr, op, pi, co);
        if (!r)              m_sh = '0;
        else if (run || up)  m_sh = m_sr;
        @(negedge tck);
        #2;
        chk(req, "pin_q", 32'(pin_q), 32'(m_sh[7:0]));
        chk(req, "core_in", 32'(core_in), 32'(m_sh[15:8]));
        chk("R10", "pin_oe", 32'(pin_oe), 32'({{4{m_sh[17]}}, {4{m_sh[16]}}}));
        chk(req, "tdo", 32'(tdo), 32'(m_sr[0]));
        #3;
    endtask

    task automatic load(logic [17:0] v);
        for (int i = 0; i < 18; i++) step("R2", 1'b1, 1'b0, 1'b1, v[i], 1'b0, 2'b00, 8'h00, 8'h00);
        step("R2", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 8'h00, 8'h00);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] pi, co;
        logic [1:0] op;
        int period;
        void'($urandom(32'h5EED_0042));
        @(negedge tck);
        #5;
        // R1: reset state
        step("R1", 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2'b01, 8'hFF, 8'hFF);
        step("R1", 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 8'hA5, 8'h5A);
        chk("R1", "pin_oe reset", 32'(pin_oe), 32'h0);

        // R6: all-zero seed stays at zero
        load(18'h0);
        for (int i = 0; i < 20; i++) step("R6", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 8'hFF, 8'hFF);
        chk("R6", "zero seed data", 32'({core_in, pin_q}), 32'h0);

        // R4: toggle twice restores outputs
        load(18'h3_00C3);
        step("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 8'h96, 8'h00);
        chk("R4", "toggled out", 32'(pin_q), 32'h3C);
        step("R4", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 8'h11, 8'h00);
        chk("R4", "toggled back", 32'(pin_q), 32'hC3);
        chk("R4", "sampled in", 32'(core_in), 32'h11);

        // R3: hold with update strobe only
        step("R3", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 8'hEE, 8'h77);
        chk("R3", "held out", 32'(pin_q), 32'hC3);

        // R5 and R9: full period from seed 0x0001, enables from control cells
        load(18'h2_0001);
        period = 0;
        for (int i = 1; i <= 65535; i++) begin
            step("R5", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01, 8'h00, 8'h00);
            if (period == 0 && {core_in, pin_q} == 16'h0001) period = i;
        end
        chk("R5", "period", 32'(period), 32'd65535);
        chk("R9", "pin_oe after run", 32'(pin_oe), 32'hF0);

        // R8: split mode directed
        load(18'h1_8001);
        step("R8", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 8'h0F, 8'hFF);
        chk("R8", "split in", 32'(core_in), 32'h0E);
        chk("R8", "split out", 32'(pin_q), 32'h02);

        // R7: signature directed
        load(18'h0_0000);
        step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 8'h12, 8'h34);
        chk("R7", "sig first", 32'({core_in, pin_q}), 32'h1234);

        // random mix across all modes
        for (int i = 0; i < 4000; i++) begin
            logic run, sh, up, ti;
            string tag;
            op = 2'($urandom());
            pi = 8'($urandom());
            co = 8'($urandom());
            run = ($urandom() % 4) != 0;
            sh = ($urandom() % 10) == 0;
            up = ($urandom() % 8) == 0;
            ti = 1'($urandom());
            if (sh)        tag = "R2";
            else if (!run) tag = "R3";
            else case (op)
                2'b00:   tag = "R4";
                2'b01:   tag = "R5";
                2'b10:   tag = "R7";
                default: tag = "R8";
            endcase
            step(tag, 1'b1, run, sh, ti, up, op, pi, co);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule